// File: doc/BRIEF.md
# DDR Pair Output Formatter

The formatter sits between a sampling converter core and the chip's data pins. Once per sample period it takes one parallel sample and an over-range flag. After a fixed pipeline delay it drives the sample out in one of two forms, together with a forwarded clock that the receiver uses to capture the data.

In pair mode, lane `k` carries two neighbouring sample bits. The even bit `2k` comes first and the odd bit `2k+1` follows half a sample period later. The receiver captures the even half on the falling edge of the forwarded clock and the odd half on its rising edge. A 14-bit sample therefore needs 7 lanes and a 12-bit sample needs 6. In word mode, every sample bit has its own lane, and the forwarded clock rises once in the middle of each sample period.

`clk_i` runs at four times the sample rate. Each sample period is one slot of four quarters. The counter is zero at reset, and the conversion edges are every fourth `clk_i` rising edge after reset release, starting with the fourth. The 1-bit mode register defaults to pair mode and is written through a small configuration strobe. An output-disable input forces every output to an idle low level, standing in for a high-impedance state.

Top module: `ddr_pair_fmt`

## Requirements
- R1: In pair mode, `data_o[k]` carries sample bits `2k` (even half) and `2k+1` (odd half) for `k < (SAMPLE_W+1)/2`: 7 lanes at 14 bits, 6 lanes at 12 bits. All `data_o` bits above the last lane are 0.
- R2: In pair mode, quarters 0 and 1 of a slot show the even bits and quarters 2 and 3 show the odd bits. Data therefore changes only at the start of quarters 0 and 2, half a sample period apart.
- R3: In pair mode, `fclk_o` is high in quarters 3 and 0 and low in quarters 1 and 2. Its falling edge lands mid-way through the even window and its rising edge mid-way through the odd window, so a receiver using both edges recovers the whole word.
- R4: In word mode, `data_o[i]` is sample bit `i` for all four quarters. `fclk_o` is low in quarters 0 and 1 and high in quarters 2 and 3, so it rises in the middle of the data eye.
- R5: A sample is captured at a conversion edge. Quarter 0 of its slot appears just after the `clk_i` edge that comes `4*LATENCY` cycles later (`LATENCY` defaults to 10 sample periods).
- R6: The mode register (0 = pair, 1 = word) resets to pair mode. It is loaded from `cfg_par_i` only at an edge where `cfg_wr_i` is high; at any other edge, `cfg_par_i` is ignored.
- R7: A new mode takes effect from the first slot whose start edge comes strictly after the write edge. A write at a slot-start edge therefore takes effect one slot later.
- R8: `ovr_o` carries the over-range flag of the sample shown in the current slot, for all four quarters, in both modes.
- R9: After any edge at which `out_dis_i` is high, `data_o`, `fclk_o` and `ovr_o` are all 0. The pipeline keeps advancing, so output resumes on the normal schedule once the input drops.
- R10: While `rst_ni` is low, all outputs are 0 and the pipeline is cleared. Slots that start before the first real sample arrives show a zero word with pair-mode clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quarter-rate clock, four cycles per sample period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | SAMPLE_W | Converter sample, captured at a conversion edge |
| ovr_i | input | 1 | Over-range flag travelling with the sample |
| cfg_wr_i | input | 1 | Write strobe for the mode register |
| cfg_par_i | input | 1 | Mode value written: 0 pair lanes, 1 full word |
| out_dis_i | input | 1 | Forces all outputs to idle low |
| data_o | output | SAMPLE_W | Output lanes |
| fclk_o | output | 1 | Forwarded clock at the sample rate |
| ovr_o | output | 1 | Delayed over-range flag |

## Verification
Every output is registered, so a quarter's value is visible just after the `clk_i` edge that enters that quarter. A sample's first quarter is due `4*LATENCY` edges after its capture edge. Disable and mode writes show up one edge later, and mode writes only at the next slot start. The bench drives inputs and samples outputs on the falling edge, and counts rising edges from reset release. For every cycle it derives the due slot, quarter, sample index, mode and disable state from histories of what it drove, and compares both a 14-bit and a 12-bit instance. It also deserialises the pair lanes on both forwarded-clock edges and compares each rebuilt word with the sample expected in that slot.

// File: rtl/ddr_fmt_pkg.sv
package ddr_fmt_pkg;
  localparam int unsigned QUARTERS = 4;
  localparam int unsigned PH_W     = $clog2(QUARTERS);

  typedef enum logic {
    MODE_PAIR = 1'b0,
    MODE_WORD = 1'b1
  } out_mode_e;
endpackage

// File: rtl/fmt_phase_gen.sv
module fmt_phase_gen
  import ddr_fmt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] q_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] LAST_Q = PH_W'(QUARTERS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_o + PH_W'(1);
  end

  assign wrap_o = (q_o == LAST_Q);

  // slot start strobe is one cycle wide
  p_wrap_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/fmt_sample_pipe.sv
module fmt_sample_pipe #(
  parameter int unsigned WORD_W = 15,
  parameter int unsigned DEPTH  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] dout_o
);
  logic [DEPTH-1:0][WORD_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (adv_i) begin
      stage_q[0] <= din_i;
      for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout_o = stage_q[DEPTH-1];

  p_pipe_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adv_i) |-> $stable(dout_o));
endmodule

// File: rtl/fmt_lane_packer.sv
module fmt_lane_packer
  import ddr_fmt_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PH_W-1:0]     q_i,
  input  logic                wrap_i,
  input  logic [SAMPLE_W:0]   tail_i,
  input  out_mode_e           mode_i,
  input  logic                dis_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                fclk_o,
  output logic                ovr_o
);
  localparam int unsigned LANES = (SAMPLE_W + 1) / 2;

  logic [PH_W-1:0]     q_n;
  logic [SAMPLE_W:0]   slot_q, word_n;
  out_mode_e           slot_mode_q, mode_n;
  logic [LANES-1:0]    even_bits, odd_bits;
  logic [SAMPLE_W-1:0] data_n;
  logic                fclk_n;

  assign q_n    = q_i + PH_W'(1);
  assign word_n = wrap_i ? tail_i : slot_q;
  assign mode_n = wrap_i ? mode_i : slot_mode_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign even_bits[l] = word_n[2*l];
    if (2*l + 1 < SAMPLE_W) begin : g_odd
      assign odd_bits[l] = word_n[2*l+1];
    end else begin : g_pad
      assign odd_bits[l] = 1'b0;
    end
  end

  always_comb begin
    data_n = '0;
    if (mode_n == MODE_WORD) begin
      data_n = word_n[SAMPLE_W-1:0];
      fclk_n = q_n[PH_W-1];
    end else begin
      // second half of the slot carries the odd bits
      data_n[LANES-1:0] = q_n[PH_W-1] ? odd_bits : even_bits;
      fclk_n = (q_n == '0) || (q_n == PH_W'(QUARTERS - 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= '0;
      slot_mode_q <= MODE_PAIR;
      data_o      <= '0;
      fclk_o      <= 1'b0;
      ovr_o       <= 1'b0;
    end else begin
      slot_q      <= word_n;
      slot_mode_q <= mode_n;
      if (dis_i) begin
        data_o <= '0;
        fclk_o <= 1'b0;
        ovr_o  <= 1'b0;
      end else begin
        data_o <= data_n;
        fclk_o <= fclk_n;
        ovr_o  <= word_n[SAMPLE_W];
      end
    end
  end

  p_idle_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dis_i) |-> (data_o == '0) && !fclk_o && !ovr_o);

  // quarters 1 and 3 never start a new data window
  p_mid_quarter_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_i == PH_W'(1)) || (q_i == PH_W'(3))) && !$past(dis_i) && !$past(dis_i, 2)
      |-> $stable(data_o) && $stable(ovr_o));

  p_mode_at_slot_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wrap_i) |-> $stable(slot_mode_q));
endmodule

// File: rtl/ddr_pair_fmt.sv
module ddr_pair_fmt
  import ddr_fmt_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned LATENCY  = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                ovr_i,
  input  logic                cfg_wr_i,
  input  logic                cfg_par_i,
  input  logic                out_dis_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                fclk_o,
  output logic                ovr_o
);
  localparam int unsigned WORD_W = SAMPLE_W + 1;

  logic [PH_W-1:0]   q;
  logic              wrap;
  logic [WORD_W-1:0] tail;
  out_mode_e         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_PAIR;
    else if (cfg_wr_i) mode_q <= out_mode_e'(cfg_par_i);
  end

  fmt_phase_gen i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_o    (q),
    .wrap_o (wrap)
  );

  fmt_sample_pipe #(
    .WORD_W (WORD_W),
    .DEPTH  (LATENCY)
  ) i_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wrap),
    .din_i  ({ovr_i, sample_i}),
    .dout_o (tail)
  );

  fmt_lane_packer #(
    .SAMPLE_W (SAMPLE_W)
  ) i_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_i    (q),
    .wrap_i (wrap),
    .tail_i (tail),
    .mode_i (mode_q),
    .dis_i  (out_dis_i),
    .data_o (data_o),
    .fclk_o (fclk_o),
    .ovr_o  (ovr_o)
  );

  p_mode_write_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_wr_i) |-> $stable(mode_q));
endmodule

// File: tb/test_ddr_pair_fmt.sv
`timescale 1ns/1ps
module test_ddr_pair_fmt;
  localparam int W    = 14;
  localparam int W2   = 12;
  localparam int LAT  = 10;
  localparam int NCYC = 1400;
  localparam int NSMP = NCYC / 4 + 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [W-1:0]  smp;
  logic          ovr;
  logic          cfg_wr, cfg_par, dis;
  logic [W-1:0]  data14;
  logic [W2-1:0] data12;
  logic          fclk14, fclk12, ovr14, ovr12;

  int total = 0;
  int bad   = 0;
  int kc    = 0;
  bit done  = 1'b0;

  logic [W-1:0] samp_h [NSMP];
  logic         ovr_h  [NSMP];
  logic         mode_h [NCYC+2];
  logic         dis_h  [NCYC+2];
  logic [W-1:0] rx_even;

  always #2.5 clk = ~clk;

  ddr_pair_fmt #(.SAMPLE_W(W), .LATENCY(LAT)) i_ddr_pair_fmt (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(smp), .ovr_i(ovr),
    .cfg_wr_i(cfg_wr), .cfg_par_i(cfg_par), .out_dis_i(dis),
    .data_o(data14), .fclk_o(fclk14), .ovr_o(ovr14));

  ddr_pair_fmt #(.SAMPLE_W(W2), .LATENCY(LAT)) i_ddr_pair_fmt_12 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(smp[W2-1:0]), .ovr_i(ovr),
    .cfg_wr_i(cfg_wr), .cfg_par_i(cfg_par), .out_dis_i(dis),
    .data_o(data12), .fclk_o(fclk12), .ovr_o(ovr12));

  task automatic chk(bit ok, string tag, string what, int k, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s k=%0d act=%h exp=%h", tag, what, k, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dec_data(logic [W-1:0] wd, logic par, int q, int w);
    logic [W-1:0] r = '0;
    if (par) begin
      for (int i = 0; i < w; i++) r[i] = wd[i];
    end else begin
      for (int l = 0; l < (w + 1) / 2; l++) begin
        int b = (q >= 2) ? 2*l + 1 : 2*l;
        r[l] = (b < w) ? wd[b] : 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic dec_fclk(logic par, int q);
    return par ? (q >= 2) : (q == 0 || q == 3);
  endfunction

  function automatic int slot_idx(int k);
    return (k - k % 4) / 4 - LAT - 1;
  endfunction

  function automatic logic slot_mode(int k);
    int ks = k - k % 4;
    return (ks >= 4) ? mode_h[ks-1] : 1'b0;
  endfunction

  task automatic check_cycle(int k);
    int q = k % 4;
    int m = slot_idx(k);
    logic par = slot_mode(k);
    logic pprev = (k - q >= 8) ? mode_h[k-q-5] : 1'b0;
    logic [W-1:0] wd = (m >= 0) ? samp_h[m] : '0;
    logic ov = (m >= 0) ? ovr_h[m] : 1'b0;
    logic [W-1:0] e14, e12;
    logic ef;
    string tg, tf;
    if (dis_h[k]) begin
      e14 = '0; e12 = '0; ef = 1'b0; ov = 1'b0; tg = "R9"; tf = "R9";
    end else begin
      e14 = dec_data(wd, par, q, W);
      e12 = dec_data(wd, par, q, W2);
      ef  = dec_fclk(par, q);
      if (m < 0)              tg = "R10";
      else if (par != pprev)  tg = "R7 R5";
      else if (par)           tg = "R4 R5";
      else                    tg = "R2 R5";
      tf = par ? "R4" : (k <= 400 ? "R3 R6" : "R3");
    end
    chk(data14 == e14, tg, "data14", k, data14, e14);
    chk({2'b00, data12} == e12, dis_h[k] ? "R9" : "R1", "data12", k, {2'b00, data12}, e12);
    chk(fclk14 == ef && fclk12 == ef, tf, "fclk", k, {13'd0, fclk14}, {13'd0, ef});
    chk(ovr14 == ov && ovr12 == ov, dis_h[k] ? "R9" : "R8", "ovr", k, {13'd0, ovr14}, {13'd0, ov});
  endtask

  task automatic drive(int k);
    int e = k + 1;
    logic wr = (e == 401) || (e == 704) || (e == 1002) || (e == 1300);
    logic pv = (e == 401) || (e == 1002);
    cfg_wr  = wr;
    cfg_par = wr ? pv : 1'($urandom);
    dis     = (e >= 300 && e <= 309) || (e >= 850 && e <= 853) || (e == 1101);
    mode_h[e] = wr ? pv : mode_h[e-1];
    dis_h[e]  = dis;
    if (k % 4 == 0) begin
      int m = k / 4;
      logic [W-1:0] s = W'($urandom);
      logic o = ($urandom % 8) == 0;
      case (m)
        3, 120:  begin s = 14'h3FFF; o = 1'b1; end
        4, 121:  begin s = 14'h0000; o = 1'b0; end
        5, 122:  begin s = 14'h2AAA; o = 1'b0; end
        6, 123:  begin s = 14'h1555; o = 1'b1; end
        default: ;
      endcase
      samp_h[m] = s;
      ovr_h[m]  = o;
      smp = s;
      ovr = o;
    end
  endtask

  // receiver: even half on falling edge, odd half on rising edge
  always @(negedge fclk14) begin
    for (int l = 0; l < W / 2; l++) rx_even[2*l] = data14[l];
  end

  always @(posedge fclk14) begin
    #1;
    begin
      int kd = kc + 1;
      int m = slot_idx(kd);
      if (rst_ni && kd % 4 == 3 && kd >= 4 && m >= 0 && !slot_mode(kd) &&
          !dis_h[kd] && !dis_h[kd-1] && !dis_h[kd-2] && !dis_h[kd-3]) begin
        logic [W-1:0] w = rx_even;
        for (int l = 0; l < W / 2; l++) w[2*l+1] = data14[l];
        chk(w == samp_h[m], "R3", "deser", kd, w, samp_h[m]);
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mode_h[0] = 1'b0;
    dis_h[0]  = 1'b0;
    rst_ni = 1'b0; smp = '0; ovr = 1'b0; cfg_wr = 1'b0; cfg_par = 1'b1; dis = 1'b0;
    repeat (4) @(negedge clk);
    chk(data14 == '0 && data12 == '0, "R10", "reset data", 0, data14, '0);
    chk(!fclk14 && !fclk12 && !ovr14 && !ovr12, "R10", "reset clk/ovr", 0,
        {12'd0, fclk14, ovr14}, '0);
    rst_ni = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      kc = k;
      if (k >= 1) check_cycle(k);
      drive(k);
      @(negedge clk);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(NCYC * 5 + 2000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule